// File: doc/BRIEF.md
# Single-Slope Ramp Converter Sequencer

This block sequences a multi-channel single-slope analog-to-digital conversion. It toggles one digital output that feeds an external RC network. The network turns the square wave into a rising reference ramp while the output is high and a falling ramp while it is low. One comparator per channel watches that shared ramp, and a time-to-digital front end turns each comparator transition into a crossing event with a small fine-time code.

The block timestamps each crossing. The timestamp is the coarse clock count since the start of the current ramp half, joined with the fine code. The upper bits of the timestamp index a loadable 256-entry table, and the table holds the inverse of the RC ramp's nonlinear voltage curve. The block reports one voltage code per channel for every ramp half, rising and falling. Each result is tagged with the ramp half it came from. A channel whose input was never crossed in a half reports a saturation code instead.

Top module: `slope_adc_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `ramp_drv` is high and no bit of `res_vld` is set.
- R2: `ramp_drv` starts high after reset and holds each level for exactly `half_len` clocks. A `half_len` of 0 behaves as 1. High marks the leading (rising) half and low marks the trailing (falling) half.
- R3: A crossing's timestamp is {coarse count, fine code}. The coarse count is 0 in the first clock of a half and increases by 1 each clock. The table index is the top 8 bits of the timestamp, which is {count[6:0], fine[1]} with the default widths.
- R4: A crossing accepted in clock k sets that channel's `res_vld` for one clock in clock k+1. `res_code` then carries the table entry at the crossing's index, and `res_trail` is 1 if the crossing fell in a trailing half and 0 if it fell in a leading half.
- R5: Only the first crossing of a channel in a half is accepted. Any later crossing of that channel in the same half produces no output.
- R6: A channel with no crossing by the last clock of a half reports the saturation code 0xFFF in the following clock, tagged with that half's phase.
- R7: Channels are independent. Crossings on different channels in the same clock or in different clocks are each reported per R4 to R6.
- R8: When `tbl_we` is high at a clock edge, `tbl_data` is stored at `tbl_addr`. A crossing in any later clock that reads that index gets the new value.
- R9: A crossing in the last clock of a half counts for that half and suppresses its saturation report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_len | input | 7 | Clocks per ramp half, held stable out of reset |
| ramp_drv | output | 1 | Drive to the external RC network |
| cross_vld | input | 4 | Per-channel crossing event in this clock |
| cross_fine | input | 8 | Per-channel 2-bit fine code, channel c at bits [2c+1:2c] |
| tbl_we | input | 1 | Conversion table write enable |
| tbl_addr | input | 8 | Conversion table write index |
| tbl_data | input | 12 | Conversion table write value |
| res_vld | output | 4 | Per-channel result strobe |
| res_code | output | 48 | Per-channel voltage code, channel c at bits [12c+11:12c] |
| res_trail | output | 4 | Per-channel phase tag of the result, 1 = trailing half |

## Verification
The checker watches every cycle and covers four things: the hold time of each ramp level against `half_len`, that each strobe carries the phase that was current one clock earlier, that every strobe follows either a crossing or a ramp edge, and that no channel strobes twice within one half. Only the bench scenarios can show the values themselves. These are the codes read through the nonlinear table for given counts and fine codes, the saturation value, the dropping of repeated crossings, and that a table rewrite takes effect.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

    typedef enum logic {
        PH_LEAD  = 1'b0,
        PH_TRAIL = 1'b1
    } phase_e;

endpackage

// File: rtl/slope_ramp_timer.sv
module slope_ramp_timer
    import slope_adc_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_len,
    output logic [CW-1:0] cnt_o,
    output phase_e        phase_o,
    output logic          last_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        phase_e        phase;
    } tmr_t;

    tmr_t s_q, s_d;
    logic last;

    always_comb begin
        s_d  = s_q;
        last = ({1'b0, s_q.cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, half_len};
        if (last) begin
            s_d.cnt   = '0;
            s_d.phase = (s_q.phase == PH_LEAD) ? PH_TRAIL : PH_LEAD;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.phase <= PH_LEAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o   = s_q.cnt;
    assign phase_o = s_q.phase;
    assign last_o  = last;

endmodule

// File: rtl/slope_conv_table.sv
module slope_conv_table #(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH*AW-1:0] raddr,
    output logic [NCH*DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign rdata[c*DW +: DW] = mem_q[raddr[c*AW +: AW]];
    end

endmodule

// File: rtl/slope_chan_capture.sv
module slope_chan_capture
    import slope_adc_pkg::*;
#(
    parameter int CW = 7,
    parameter int FW = 2,
    parameter int AW = 8,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_i,
    input  logic [FW-1:0] fine_i,
    input  logic [CW-1:0] cnt_i,
    input  phase_e        phase_i,
    input  logic          last_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    output logic          vld_o,
    output logic [DW-1:0] code_o,
    output logic          trail_o
);

    localparam int TSW = CW + FW;
    localparam int SH  = TSW - AW;
    localparam logic [DW-1:0] SAT = '1;

    typedef struct packed {
        logic          hit;
        logic          vld;
        logic          trail;
        logic [DW-1:0] code;
    } cap_t;

    cap_t s_q, s_d;
    logic [TSW-1:0] stamp;
    logic take, miss;

    always_comb begin
        stamp     = {cnt_i, fine_i};
        rd_addr_o = AW'(stamp >> SH);
        take      = ev_i && !s_q.hit;
        miss      = last_i && !s_q.hit && !ev_i;
        s_d       = s_q;
        s_d.hit   = last_i ? 1'b0 : (s_q.hit | ev_i);
        s_d.vld   = take | miss;
        s_d.trail = (phase_i == PH_TRAIL);
        if (miss) begin
            s_d.code = SAT;
        end else if (take) begin
            s_d.code = rd_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o   = s_q.vld;
    assign code_o  = s_q.code;
    assign trail_o = s_q.trail;

endmodule

// File: rtl/slope_adc_seq.sv
module slope_adc_seq
    import slope_adc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 7,
    parameter int FW  = 2,
    parameter int AW  = 8,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     half_len,
    output logic              ramp_drv,
    input  logic [NCH-1:0]    cross_vld,
    input  logic [NCH*FW-1:0] cross_fine,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [DW-1:0]     tbl_data,
    output logic [NCH-1:0]    res_vld,
    output logic [NCH*DW-1:0] res_code,
    output logic [NCH-1:0]    res_trail
);

    logic [CW-1:0]     cnt;
    phase_e            phase;
    logic              last;
    logic [NCH*AW-1:0] rd_addr;
    logic [NCH*DW-1:0] rd_data;

    slope_ramp_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_len (half_len),
        .cnt_o    (cnt),
        .phase_o  (phase),
        .last_o   (last)
    );

    assign ramp_drv = (phase == PH_LEAD);

    slope_conv_table #(.NCH(NCH), .AW(AW), .DW(DW)) u_table (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        slope_chan_capture #(.CW(CW), .FW(FW), .AW(AW), .DW(DW)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_i      (cross_vld[c]),
            .fine_i    (cross_fine[c*FW +: FW]),
            .cnt_i     (cnt),
            .phase_i   (phase),
            .last_i    (last),
            .rd_addr_o (rd_addr[c*AW +: AW]),
            .rd_data_i (rd_data[c*DW +: DW]),
            .vld_o     (res_vld[c]),
            .code_o    (res_code[c*DW +: DW]),
            .trail_o   (res_trail[c])
        );
    end

endmodule

// File: rtl/slope_adc_seq_chk.sv
module slope_adc_seq_chk #(
    parameter int NCH = 4,
    parameter int CW  = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  half_len,
    input logic           ramp_drv,
    input logic [NCH-1:0] cross_vld,
    input logic [NCH-1:0] res_vld,
    input logic [NCH-1:0] res_trail
);

    logic          prev_q;
    logic [CW:0]   lvl_q;
    logic [CW:0]   eff_len;

    assign eff_len = (half_len == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, half_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            lvl_q  <= '0;
        end else begin
            prev_q <= ramp_drv;
            lvl_q  <= (ramp_drv != prev_q) ? {{CW{1'b0}}, 1'b1} : lvl_q + 1'b1;
        end
    end

    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_drv != prev_q) |-> (lvl_q == eff_len)); // R2

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_PHASE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
            res_vld[c] |-> (res_trail[c] == !$past(ramp_drv))); // R4

        AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            res_vld[c] |-> ($past(cross_vld[c]) || (ramp_drv != $past(ramp_drv)))); // R6

        AST_ONE_PER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (res_vld[c] && $past(res_vld[c])) |-> (res_trail[c] != $past(res_trail[c]))); // R5
    end

endmodule

bind slope_adc_seq slope_adc_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_len  (half_len),
    .ramp_drv  (ramp_drv),
    .cross_vld (cross_vld),
    .res_vld   (res_vld),
    .res_trail (res_trail)
);

// File: tb/tb_slope_adc_seq.sv
module tb_slope_adc_seq;

    localparam int NCH = 4;
    localparam int L   = 12;
    localparam logic [11:0] SAT = 12'hFFF;
    localparam logic [7:0]  NONE = 8'hFF;

    typedef struct packed {
        logic            rep;
        logic [3:0][1:0] fine;
        logic [3:0][7:0] off;
    } vec_t;

    // channel order in each list: ch3, ch2, ch1, ch0
    localparam vec_t VEC [6] = '{
        '{rep: 1'b0, fine: {2'd3, 2'd2, 2'd1, 2'd0}, off: {8'd11, 8'd7, 8'd3, 8'd0}},
        '{rep: 1'b1, fine: {2'd0, 2'd1, 2'd2, 2'd3}, off: {8'd11, 8'd2, NONE, 8'd5}},
        '{rep: 1'b0, fine: {2'd0, 2'd0, 2'd0, 2'd0}, off: {NONE, NONE, NONE, NONE}},
        '{rep: 1'b1, fine: {2'd3, 2'd2, 2'd1, 2'd0}, off: {8'd1, 8'd1, 8'd1, 8'd1}},
        '{rep: 1'b1, fine: {2'd2, 2'd3, 2'd0, 2'd1}, off: {NONE, 8'd6, 8'd0, 8'd11}},
        '{rep: 1'b0, fine: {2'd1, 2'd2, 2'd3, 2'd2}, off: {8'd10, NONE, 8'd9, 8'd4}}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  half_len = 7'd12;
    logic        ramp_drv;
    logic [3:0]  cross_vld = '0;
    logic [7:0]  cross_fine = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [11:0] tbl_data = '0;
    logic [3:0]  res_vld;
    logic [47:0] res_code;
    logic [3:0]  res_trail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slope_adc_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_len   (half_len),
        .ramp_drv   (ramp_drv),
        .cross_vld  (cross_vld),
        .cross_fine (cross_fine),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_data   (tbl_data),
        .res_vld    (res_vld),
        .res_code   (res_code),
        .res_trail  (res_trail)
    );

    function automatic logic [11:0] curve(input int a);
        return 12'((a * a) / 32 + a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_phase(input vec_t v, input bit trl);
        for (int k = 0; k < L; k++) begin
            chk(ramp_drv == !trl, "R2", "ramp level", int'(ramp_drv), int'(!trl));
            for (int c = 0; c < NCH; c++) begin
                cross_vld[c] = (v.off[c] == 8'(k)) ||
                               (v.rep && v.off[c] != NONE && v.off[c] + 8'd1 == 8'(k));
                cross_fine[2*c +: 2] = v.fine[c];
            end
            step();
            for (int c = 0; c < NCH; c++) begin
                bit ev_hit = (v.off[c] == 8'(k));
                bit ev_sat = (v.off[c] == NONE) && (k == L - 1);
                bit exp_v  = ev_hit || ev_sat;
                chk(res_vld[c] == exp_v, "R5/R7", "strobe", int'(res_vld[c]), int'(exp_v));
                if (exp_v) begin
                    logic [11:0] exp_c;
                    exp_c = ev_sat ? SAT : curve(int'({v.off[c][6:0], v.fine[c][1]}));
                    if (ev_sat)
                        chk(res_code[12*c +: 12] == exp_c, "R6", "sat code",
                            int'(res_code[12*c +: 12]), int'(exp_c));
                    else if (k == L - 1)
                        chk(res_code[12*c +: 12] == exp_c, "R9", "last-clock code",
                            int'(res_code[12*c +: 12]), int'(exp_c));
                    else
                        chk(res_code[12*c +: 12] == exp_c, "R3/R4", "code",
                            int'(res_code[12*c +: 12]), int'(exp_c));
                    chk(res_trail[c] == trl, "R4", "phase tag", int'(res_trail[c]), int'(trl));
                end
            end
        end
        cross_vld = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // load the table while reset holds the ramp still
        for (int a = 0; a < 256; a++) begin
            tbl_we   = 1'b1;
            tbl_addr = 8'(a);
            tbl_data = curve(a);
            step();
        end
        tbl_we = 1'b0;
        chk(ramp_drv == 1'b1, "R1", "drive in reset", int'(ramp_drv), 1);
        chk(res_vld == 4'b0, "R1", "strobe in reset", int'(res_vld), 0);
        rst_n = 1'b1;
        chk(ramp_drv == 1'b1, "R1", "drive after reset", int'(ramp_drv), 1);

        for (int i = 0; i < 6; i++) begin
            run_phase(VEC[i], i[0]);
        end

        // R8: rewrite one entry, then read it in the same half
        for (int k = 0; k < L; k++) begin
            tbl_we   = (k == 0);
            tbl_addr = 8'd6;
            tbl_data = 12'hABC;
            cross_vld  = (k == 3) ? 4'b0001 : 4'b0000;
            cross_fine = '0;
            step();
            if (k == 3) begin
                chk(res_vld[0] == 1'b1, "R8", "strobe", int'(res_vld[0]), 1);
                chk(res_code[11:0] == 12'hABC, "R8", "new entry", int'(res_code[11:0]), 'hABC);
            end
            if (k == L - 1)
                chk(res_vld[1] && res_code[23:12] == SAT, "R6", "sat ch1",
                    int'(res_code[23:12]), int'(SAT));
        end
        tbl_we = 1'b0;
        cross_vld = '0;

        // R2: other half lengths
        rst_n = 1'b0;
        half_len = 7'd5;
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            chk(ramp_drv == ((k / 5) % 2 == 0), "R2", "len 5", int'(ramp_drv),
                int'((k / 5) % 2 == 0));
            step();
        end
        rst_n = 1'b0;
        half_len = 7'd0;
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            chk(ramp_drv == (k % 2 == 0), "R2", "len 0", int'(ramp_drv), int'(k % 2 == 0));
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule